// File: doc/BRIEF.md
# Page Directory State Controller

This block keeps one directory entry per shared page for a software-coherent multiprocessor. Each entry holds a reader bitmap and a writer bitmap indexed by processor number, a global page state (Uncached, Shared, Dirty or Weak), an "unsafe" flag that is independent of the state, and a per-entry lock with an owner. The state belongs to the page as a whole. It is not a per-processor view.

Processors send requests on one port. A request carries a processor number, a page index and an operation. A processor takes the entry's lock, then reports read faults, write faults or self-invalidations, then gives the lock back. Every request receives a registered response one cycle after acceptance. The response carries a result code and the entry contents after the operation.

When a fault moves a page into Weak, the block streams one write notice to each other sharer over a valid/ready output. It does not do this when the page is flagged unsafe. If a single transition produces at least `UNSAFE_TH` notices, the page is flagged unsafe after the last of those notices has been accepted.

Top module: `pdc_top`

## Requirements
- R1: After reset every entry is Uncached with empty bitmaps, a clear unsafe flag and no lock holder. `req_ready` is 1, and `nt_valid` and `rsp_valid` are 0.
- R2: Operation 0 (take lock) succeeds when the entry is free or already held by the requester. It answers retry when another processor holds the entry. Operation 1 (give lock) frees the entry only for its holder and answers retry for anyone else.
- R3: Operations 2 (read fault), 3 (write fault) and 4 (self-invalidate) take effect only when the requester holds the entry's lock. Otherwise they answer retry and leave the entry unchanged.
- R4: A read fault sets the requester's bit in the reader bitmap. A write fault sets it in the writer bitmap. Bit i of each bitmap stands for processor i.
- R5: The state is encoded 0 Uncached (no sharer), 1 Shared (at least one sharer and no writer), 2 Dirty (exactly one sharer, and it writes) and 3 Weak (two or more sharers, at least one of which writes). The sharers are the union of the readers and the writers.
- R6: A self-invalidate clears the requester from both bitmaps. When no sharer is left, the state becomes Uncached.
- R7: An applied fault that moves a page from another state into Weak, while its unsafe flag is clear, emits exactly one notice for each sharer other than the requester. The notices come in ascending processor order, and each carries the page index.
- R8: A fault that leaves a page Weak emits no notice. A transition into Weak on a page whose unsafe flag is set emits no notice either.
- R9: When one transition emits at least `UNSAFE_TH` notices, the page's unsafe flag is set after the last of them is accepted. Later responses for that page show it. Fewer notices leave the flag unchanged.
- R10: A notice that is not accepted stays valid with a stable processor and page. `req_ready` is 0 while any notice is pending.
- R11: Each accepted request produces `rsp_valid` exactly one cycle later, and no response appears otherwise. Codes are 0 done, 1 retry and 2 unknown operation. Operations 5 to 7 are unknown and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (no notice pending) |
| req_pid | input | log2(NPROC) | Requesting processor |
| req_page | input | log2(NPAGE) | Page index |
| req_op | input | 3 | Operation code |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 done, 1 retry, 2 unknown operation |
| rsp_state | output | 2 | Page state after the operation |
| rsp_unsafe | output | 1 | Unsafe flag of the page |
| rsp_readers | output | NPROC | Reader bitmap after the operation |
| rsp_writers | output | NPROC | Writer bitmap after the operation |
| nt_valid | output | 1 | Write notice present |
| nt_ready | input | 1 | Notice consumer ready |
| nt_pid | output | log2(NPROC) | Processor to notify |
| nt_page | output | log2(NPAGE) | Page named by the notice |

## Verification
The checker tests several properties on every clock. It checks that the response follows acceptance by exactly one cycle. It checks that each reported state agrees with the shape of the reported bitmaps. It checks that a stalled notice holds steady and that requests are refused while notices drain.

Other behaviour needs history across many requests, so only the bench scenarios can show it. That includes lock ownership and retry, the exact set and order of notices on entry into Weak, the silence on pages already Weak or unsafe, and the late setting of the unsafe flag. The bench covers these with a scripted sequence and a long pseudo-random sweep over four processors and four pages, with notice backpressure turned on and off.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam logic [2:0] OP_LOCK   = 3'd0;
  localparam logic [2:0] OP_UNLOCK = 3'd1;
  localparam logic [2:0] OP_RDF    = 3'd2;
  localparam logic [2:0] OP_WRF    = 3'd3;
  localparam logic [2:0] OP_SINV   = 3'd4;

  localparam logic [1:0] RSP_OK    = 2'd0;
  localparam logic [1:0] RSP_RETRY = 2'd1;
  localparam logic [1:0] RSP_BADOP = 2'd2;

  typedef enum logic [1:0] {
    PG_UNC  = 2'd0,
    PG_SHR  = 2'd1,
    PG_DRT  = 2'd2,
    PG_WEAK = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pdc_entry_update.sv
module pdc_entry_update
  import pdc_pkg::*;
#(
  parameter int NPROC     = 8,
  parameter int PW        = 3,
  parameter int UNSAFE_TH = 4
) (
  input  logic [2:0]       op,
  input  logic [PW-1:0]    pid,
  input  logic [NPROC-1:0] rd_in,
  input  logic [NPROC-1:0] wr_in,
  input  pg_state_e        st_in,
  input  logic             uns_in,
  output logic [NPROC-1:0] rd_out,
  output logic [NPROC-1:0] wr_out,
  output pg_state_e        st_out,
  output logic [NPROC-1:0] ntf_mask,
  output logic             ntf_heavy
);
  localparam int CW = $clog2(NPROC + 1);

  logic [NPROC-1:0] me;
  logic [NPROC-1:0] sharers;
  logic [CW-1:0]    n_sh;
  logic [CW-1:0]    n_nt;

  always_comb begin
    me     = NPROC'(1) << pid;
    rd_out = rd_in;
    wr_out = wr_in;
    case (op)
      OP_RDF:  rd_out = rd_in | me;
      OP_WRF:  wr_out = wr_in | me;
      OP_SINV: begin
        rd_out = rd_in & ~me;
        wr_out = wr_in & ~me;
      end
      default: ;
    endcase

    sharers = rd_out | wr_out;
    n_sh = '0;
    for (int i = 0; i < NPROC; i++) n_sh += CW'(sharers[i]);

    if (n_sh == '0)           st_out = PG_UNC;
    else if (wr_out == '0)    st_out = PG_SHR;
    else if (n_sh == CW'(1))  st_out = PG_DRT;
    else                      st_out = PG_WEAK;

    // notices only on entry into weak for a page not yet flagged unsafe
    ntf_mask = (st_out == PG_WEAK && st_in != PG_WEAK && !uns_in) ? (sharers & ~me) : '0;
    n_nt = '0;
    for (int i = 0; i < NPROC; i++) n_nt += CW'(ntf_mask[i]);
    ntf_heavy = (ntf_mask != '0) && (int'(n_nt) >= UNSAFE_TH);
  end
endmodule

// File: rtl/pdc_notice_q.sv
module pdc_notice_q #(
  parameter int NPROC = 8,
  parameter int PW    = 3,
  parameter int GW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NPROC-1:0] load_mask,
  input  logic [GW-1:0]    load_page,
  input  logic             load_heavy,
  input  logic             nt_ready,
  output logic             nt_valid,
  output logic [PW-1:0]    nt_pid,
  output logic [GW-1:0]    nt_page,
  output logic             busy,
  output logic             mark_set,
  output logic [GW-1:0]    mark_page
);
  logic [NPROC-1:0] mask_q;
  logic [NPROC-1:0] low;
  logic [NPROC-1:0] rest;
  logic [GW-1:0]    page_q;
  logic             heavy_q;
  logic             fire;

  always_comb begin
    low    = mask_q & ((~mask_q) + NPROC'(1));
    rest   = mask_q & ~low;
    nt_pid = '0;
    for (int i = 0; i < NPROC; i++) begin
      if (low[i]) nt_pid = PW'(i);
    end
  end

  assign nt_valid  = |mask_q;
  assign busy      = nt_valid;
  assign nt_page   = page_q;
  assign fire      = nt_valid && nt_ready;
  assign mark_set  = fire && (rest == '0) && heavy_q;
  assign mark_page = page_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      page_q  <= '0;
      heavy_q <= 1'b0;
    end else if (load) begin
      mask_q  <= load_mask;
      page_q  <= load_page;
      heavy_q <= load_heavy;
    end else if (fire) begin
      mask_q  <= rest;
    end
  end
endmodule

// File: rtl/pdc_top.sv
module pdc_top
  import pdc_pkg::*;
#(
  parameter int NPROC     = 8,
  parameter int NPAGE     = 64,
  parameter int UNSAFE_TH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [$clog2(NPROC)-1:0] req_pid,
  input  logic [$clog2(NPAGE)-1:0] req_page,
  input  logic [2:0]               req_op,
  output logic                     rsp_valid,
  output logic [1:0]               rsp_code,
  output logic [1:0]               rsp_state,
  output logic                     rsp_unsafe,
  output logic [NPROC-1:0]         rsp_readers,
  output logic [NPROC-1:0]         rsp_writers,
  output logic                     nt_valid,
  input  logic                     nt_ready,
  output logic [$clog2(NPROC)-1:0] nt_pid,
  output logic [$clog2(NPAGE)-1:0] nt_page
);
  localparam int PW = $clog2(NPROC);
  localparam int GW = $clog2(NPAGE);

  logic [NPROC-1:0] rd_q  [NPAGE];
  logic [NPROC-1:0] wr_q  [NPAGE];
  pg_state_e        st_q  [NPAGE];
  logic [PW-1:0]    own_q [NPAGE];
  logic [NPAGE-1:0] uns_q;
  logic [NPAGE-1:0] lk_q;

  logic [NPROC-1:0] upd_rd, upd_wr, ntf_mask;
  pg_state_e        upd_st;
  logic             ntf_heavy;
  logic             busy, mark_set;
  logic [GW-1:0]    mark_page;
  logic             accept, own_ok, apply, take, drop;
  logic [1:0]       code;

  pdc_entry_update #(.NPROC(NPROC), .PW(PW), .UNSAFE_TH(UNSAFE_TH)) u_upd (
    .op(req_op), .pid(req_pid),
    .rd_in(rd_q[req_page]), .wr_in(wr_q[req_page]),
    .st_in(st_q[req_page]), .uns_in(uns_q[req_page]),
    .rd_out(upd_rd), .wr_out(upd_wr), .st_out(upd_st),
    .ntf_mask(ntf_mask), .ntf_heavy(ntf_heavy)
  );

  pdc_notice_q #(.NPROC(NPROC), .PW(PW), .GW(GW)) u_ntq (
    .clk(clk), .rst(rst),
    .load(accept && apply), .load_mask(ntf_mask), .load_page(req_page),
    .load_heavy(ntf_heavy), .nt_ready(nt_ready),
    .nt_valid(nt_valid), .nt_pid(nt_pid), .nt_page(nt_page),
    .busy(busy), .mark_set(mark_set), .mark_page(mark_page)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign own_ok    = lk_q[req_page] && (own_q[req_page] == req_pid);

  always_comb begin
    code  = RSP_BADOP;
    apply = 1'b0;
    take  = 1'b0;
    drop  = 1'b0;
    case (req_op)
      OP_LOCK: begin
        if (!lk_q[req_page] || own_ok) begin code = RSP_OK; take = 1'b1; end
        else code = RSP_RETRY;
      end
      OP_UNLOCK: begin
        if (own_ok) begin code = RSP_OK; drop = 1'b1; end
        else code = RSP_RETRY;
      end
      OP_RDF, OP_WRF, OP_SINV: begin
        if (own_ok) begin code = RSP_OK; apply = 1'b1; end
        else code = RSP_RETRY;
      end
      default: code = RSP_BADOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPAGE; p++) begin
        rd_q[p]  <= '0;
        wr_q[p]  <= '0;
        st_q[p]  <= PG_UNC;
        own_q[p] <= '0;
      end
      uns_q       <= '0;
      lk_q        <= '0;
      rsp_valid   <= 1'b0;
      rsp_code    <= RSP_OK;
      rsp_state   <= 2'd0;
      rsp_unsafe  <= 1'b0;
      rsp_readers <= '0;
      rsp_writers <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_code   <= code;
        rsp_unsafe <= uns_q[req_page];
        if (apply) begin
          rd_q[req_page] <= upd_rd;
          wr_q[req_page] <= upd_wr;
          st_q[req_page] <= upd_st;
          rsp_state      <= upd_st;
          rsp_readers    <= upd_rd;
          rsp_writers    <= upd_wr;
        end else begin
          rsp_state      <= st_q[req_page];
          rsp_readers    <= rd_q[req_page];
          rsp_writers    <= wr_q[req_page];
        end
        if (take) begin
          lk_q[req_page]  <= 1'b1;
          own_q[req_page] <= req_pid;
        end
        if (drop) lk_q[req_page] <= 1'b0;
      end
      if (mark_set) uns_q[mark_page] <= 1'b1;
    end
  end
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk #(
  parameter int NPROC = 8,
  parameter int PW    = 3,
  parameter int GW    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [1:0]       rsp_state,
  input logic [NPROC-1:0] rsp_readers,
  input logic [NPROC-1:0] rsp_writers,
  input logic             nt_valid,
  input logic             nt_ready,
  input logic [PW-1:0]    nt_pid,
  input logic [GW-1:0]    nt_page
);
  // R11
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  // R11
  rsp_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  // R5
  uncached_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_state == 2'd0) |-> ((rsp_readers | rsp_writers) == '0));

  // R5
  dirty_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_state == 2'd2) |->
      ($countones(rsp_readers | rsp_writers) == 1 && rsp_writers != '0));

  // R5
  weak_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_state == 2'd3) |->
      ($countones(rsp_readers | rsp_writers) >= 2 && rsp_writers != '0));

  // R10
  notice_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (nt_valid && !nt_ready) |=> (nt_valid && $stable(nt_pid) && $stable(nt_page)));

  // R10
  drain_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
    nt_valid |-> !req_ready);
endmodule

bind pdc_top pdc_chk #(.NPROC(NPROC), .PW(PW), .GW(GW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_state(rsp_state),
  .rsp_readers(rsp_readers), .rsp_writers(rsp_writers),
  .nt_valid(nt_valid), .nt_ready(nt_ready), .nt_pid(nt_pid), .nt_page(nt_page)
);

// File: tb/sim_pdc_top.sv
module sim_pdc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NG = 4;
  localparam int TH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_pid = '0;
  logic [1:0] req_page = '0;
  logic [2:0] req_op = '0;
  logic rsp_valid;
  logic [1:0] rsp_code, rsp_state;
  logic rsp_unsafe;
  logic [NP-1:0] rsp_readers, rsp_writers;
  logic nt_valid;
  logic nt_ready = 1'b1;
  logic [1:0] nt_pid, nt_page;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdc_top #(.NPROC(NP), .NPAGE(NG), .UNSAFE_TH(TH)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_page(req_page), .req_op(req_op),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_state(rsp_state),
    .rsp_unsafe(rsp_unsafe), .rsp_readers(rsp_readers), .rsp_writers(rsp_writers),
    .nt_valid(nt_valid), .nt_ready(nt_ready), .nt_pid(nt_pid), .nt_page(nt_page)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit bp_mode = 1'b0;

  logic [NP-1:0] m_rd [NG];
  logic [NP-1:0] m_wr [NG];
  bit m_uns [NG];
  bit m_lk [NG];
  int m_own [NG];

  int got_pid [64];
  int got_pg [64];
  int got_n = 0;
  bit hold_armed = 1'b0;
  int last_pid = 0;
  int last_pg = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int st_of(input logic [NP-1:0] rd, input logic [NP-1:0] wr);
    int n;
    n = $countones(rd | wr);
    if (n == 0) return 0;
    if (wr == '0) return 1;
    if (n == 1) return 2;
    return 3;
  endfunction

  // notice consumer, backpressure and hold checks
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_armed)
        chk(nt_valid && int'(nt_pid) == last_pid && int'(nt_page) == last_pg,
            "R10 stalled notice changed", int'(nt_pid), last_pid);
      if (nt_valid) chk(!req_ready, "R10 ready while draining", int'(req_ready), 0);
    end
    if (bp_mode) nt_ready = ~nt_ready;
    else nt_ready = 1'b1;
    hold_armed = !rst && nt_valid && !nt_ready;
    last_pid = int'(nt_pid);
    last_pg = int'(nt_page);
    if (!rst && nt_valid && nt_ready && got_n < 64) begin
      got_pid[got_n] = int'(nt_pid);
      got_pg[got_n] = int'(nt_page);
      got_n++;
    end
  end

  task automatic do_req(input int pid, input int pg, input int op);
    int e_code, e_st, old_st, base, k, cnt, waitc;
    logic [NP-1:0] nrd, nwr, me, mask;
    bit own_ok, apply;
    string ctag;
    me = NP'(1) << pid;
    own_ok = m_lk[pg] && m_own[pg] == pid;
    nrd = m_rd[pg];
    nwr = m_wr[pg];
    apply = 1'b0;
    mask = '0;
    case (op)
      0: if (!m_lk[pg] || own_ok) begin e_code = 0; m_lk[pg] = 1'b1; m_own[pg] = pid; end
         else e_code = 1;
      1: if (own_ok) begin e_code = 0; m_lk[pg] = 1'b0; end
         else e_code = 1;
      2, 3, 4: if (own_ok) begin
           e_code = 0;
           apply = 1'b1;
           if (op == 2) nrd = nrd | me;
           else if (op == 3) nwr = nwr | me;
           else begin nrd = nrd & ~me; nwr = nwr & ~me; end
         end else e_code = 1;
      default: e_code = 2;
    endcase
    old_st = st_of(m_rd[pg], m_wr[pg]);
    e_st = st_of(nrd, nwr);
    if (apply && e_st == 3 && old_st != 3 && !m_uns[pg]) mask = (nrd | nwr) & ~me;

    @(negedge clk);
    waitc = 0;
    while (!req_ready && waitc < 100) begin @(negedge clk); waitc++; end
    base = got_n;
    req_valid = 1'b1;
    req_pid = pid[1:0];
    req_page = pg[1:0];
    req_op = op[2:0];
    @(negedge clk);
    req_valid = 1'b0;
    ctag = (op < 2) ? "R2 lock code" : (op < 5) ? "R3 fault code" : "R11 unknown op code";
    chk(rsp_valid == 1'b1, "R11 response strobe", int'(rsp_valid), 1);
    chk(int'(rsp_code) == e_code, ctag, int'(rsp_code), e_code);
    chk(int'(rsp_state) == e_st, "R5 state", int'(rsp_state), e_st);
    chk(rsp_readers == nrd, (op == 4) ? "R6 readers" : "R4 readers", int'(rsp_readers), int'(nrd));
    chk(rsp_writers == nwr, (op == 4) ? "R6 writers" : "R4 writers", int'(rsp_writers), int'(nwr));
    chk(rsp_unsafe == m_uns[pg], "R9 unsafe flag", int'(rsp_unsafe), int'(m_uns[pg]));

    waitc = 0;
    while (!req_ready && waitc < 100) begin @(negedge clk); waitc++; end
    cnt = $countones(mask);
    chk(got_n - base == cnt, (mask != '0) ? "R7 notice count" : "R8 notice count", got_n - base, cnt);
    k = base;
    for (int i = 0; i < NP; i++) begin
      if (mask[i] && k < got_n) begin
        chk(got_pid[k] == i && got_pg[k] == pg, "R7 notice target", got_pid[k], i);
        k++;
      end
    end
    if (cnt >= TH) m_uns[pg] = 1'b1;
    m_rd[pg] = nrd;
    m_wr[pg] = nwr;
  endtask

  initial begin
    int unsigned r;
    for (int p = 0; p < NG; p++) begin
      m_rd[p] = '0; m_wr[p] = '0; m_uns[p] = 1'b0; m_lk[p] = 1'b0; m_own[p] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(nt_valid == 1'b0, "R1 no notice after reset", int'(nt_valid), 0);
    chk(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);

    // R1: each page reads back empty and unflagged
    for (int p = 0; p < NG; p++) begin do_req(0, p, 0); do_req(0, p, 1); end

    // page 0: contention, shared, entry into weak with two notices, then unsafe
    do_req(0, 0, 0);
    do_req(1, 0, 0);          // R2 retry
    do_req(1, 0, 2);          // R3 retry, no change
    do_req(1, 0, 1);          // R2 non-holder release retries
    do_req(0, 0, 2);          // R4 shared
    do_req(0, 0, 1);
    do_req(1, 0, 0); do_req(1, 0, 2); do_req(1, 0, 1);
    do_req(2, 0, 0); do_req(2, 0, 3); do_req(2, 0, 1);   // R7 notices to 0,1; R9 flag
    do_req(3, 0, 0); do_req(3, 0, 3); do_req(3, 0, 1);   // R8 already weak
    for (int p = 0; p < NP; p++) begin do_req(p, 0, 0); do_req(p, 0, 4); do_req(p, 0, 1); end // R6
    do_req(0, 0, 0); do_req(0, 0, 2); do_req(0, 0, 1);
    do_req(1, 0, 0); do_req(1, 0, 3); do_req(1, 0, 1);   // R8 unsafe page silent

    // page 1: dirty then weak with one notice, flag must stay clear (R9)
    bp_mode = 1'b1;
    do_req(0, 1, 0); do_req(0, 1, 3); do_req(0, 1, 1);
    do_req(1, 1, 0); do_req(1, 1, 2); do_req(1, 1, 1);
    do_req(2, 1, 0); do_req(2, 1, 1);

    // page 2: three readers then a writer, three notices under backpressure (R10)
    for (int p = 0; p < 3; p++) begin do_req(p, 2, 0); do_req(p, 2, 2); do_req(p, 2, 1); end
    do_req(3, 2, 0); do_req(3, 2, 3); do_req(3, 2, 1);
    bp_mode = 1'b0;
    do_req(0, 3, 5); do_req(1, 3, 6); do_req(2, 3, 7);   // R11 unknown ops

    // pseudo-random sweep
    r = 32'h1234_5678;
    for (int n = 0; n < 1500; n++) begin
      int sel, op;
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      sel = int'(r % 16);
      if (sel < 4) op = 0;
      else if (sel < 6) op = 1;
      else if (sel < 9) op = 2;
      else if (sel < 12) op = 3;
      else if (sel < 15) op = 4;
      else op = 5 + int'((r >> 8) % 3);
      bp_mode = r[10];
      do_req(int'((r >> 4) % NP), int'((r >> 6) % NG), op);
    end
    bp_mode = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule